// File: doc/BRIEF.md
# I2C Target for Register-Memory Access

This block is an I2C target that lets a bus host read and write a byte-wide register memory through a 16-bit pointer. SCL and SDA are sampled on a fast system clock. Each line goes through a two-flop synchronizer and a short glitch filter. The filtered lines then feed the START, repeated START, STOP and bit detection.

The target answers one 7-bit address, which is set on an input pin. It supports four transactions:
- **Address-only write:** a write that carries two pointer bytes (high byte first) and then ends. It only loads the pointer.
- **Burst write:** a write whose bytes after the two pointer bytes are stored one after another.
- **Current-address read:** a read with no address phase. It streams bytes from wherever the pointer stands.
- **Combined read:** pointer bytes in write mode, then a repeated START, then a read.

The pointer survives from one transaction to the next. The memory sits outside the block behind a plain synchronous port with one cycle of read latency.

Top module: `i2c_regmem_target`

## Requirements
- R1: After the address byte with R/W bit 0, the first data byte received sets pointer bits 15:8 and the second sets bits 7:0.
- R2: A write made only of the address byte and the two pointer bytes, then STOP, loads the pointer and issues no memory write.
- R3: Each write byte after the two pointer bytes produces exactly one single-cycle `mem_we` pulse at the current pointer. The pointer then steps by one.
- R4: An address byte with R/W bit 1 returns bytes starting at the stored pointer, most significant bit first. The pointer steps by one after each byte is sent, for as many bytes as the host acknowledges.
- R5: Pointer bytes, a repeated START and then a read address byte return data starting at the newly given pointer.
- R6: The target pulls SDA low in the ninth clock after a matching address byte and after every written byte. A non-matching address gets no acknowledge, and the target ignores the bus until the next START.
- R7: A host NACK (SDA high in the ninth clock of a read byte) ends the output. SDA stays released until STOP or START.
- R8: The pointer wraps from 0xFFFF to 0x0000, and only its low ADDR_W bits address the memory.
- R9: A pulse on SCL or SDA that lasts fewer than FILT system-clock samples has no effect on START, STOP or bit detection.
- R10: The SDA drive changes only while SCL is low. A START or STOP abandons any partly received byte without storing it.
- R11: After reset the pointer is 0x0000 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least about 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the pin |
| sda_i | input | 1 | SDA line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| tgt_addr | input | 7 | 7-bit address this target answers |
| mem_addr | output | ADDR_W | Memory address, the low bits of the pointer |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid one clock after it changes |

## Verification
The bench uses ADDR_W = 8 and FILT = 3. With a 256-byte memory, random 16-bit pointers alias into it, and a burst from 0xFFFF crosses the wrap within a few bytes. With a filter of three samples, pulses of one and two cycles on either line should vanish, while a 24-cycle half bit period still leaves room for the synchronizer and filter delay before the host samples the acknowledge.

// File: rtl/i2c_regmem_target.sv
module i2c_regmem_target #(
  parameter int ADDR_W = 8,
  parameter int FILT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [6:0]        tgt_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  input  logic [7:0]        mem_rdata
);
  localparam int CW = $clog2(FILT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [1:0]    m1, m2, flt, flt_q;
  logic [CW-1:0] cnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 2'b11; m2 <= 2'b11; flt <= 2'b11; flt_q <= 2'b11;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      m1 <= {scl_i, sda_i};
      m2 <= m1;
      flt_q <= flt;
      for (int i = 0; i < 2; i++) begin
        if (m2[i] == flt[i]) cnt[i] <= '0;
        else if (cnt[i] == CW'(FILT - 1)) begin
          flt[i] <= m2[i];
          cnt[i] <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  wire scl      = flt[1];
  wire sda      = flt[0];
  wire scl_rise = scl & ~flt_q[1];
  wire scl_fall = ~scl & flt_q[1];
  wire start    = scl & flt_q[1] & flt_q[0] & ~sda;
  wire stop     = scl & flt_q[1] & ~flt_q[0] & sda;

  st_t         st;
  logic [3:0]  bcnt;
  logic [7:0]  sh;
  logic [1:0]  wcnt;
  logic        rw, nack;
  logic [15:0] ptr;

  assign mem_addr = ptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; wcnt <= '0; rw <= 1'b0; nack <= 1'b0;
      ptr <= '0; sda_oe <= 1'b0; mem_we <= 1'b0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (mem_we) ptr <= ptr + 16'd1;
      if (start) begin
        st <= S_ADDR; bcnt <= '0; wcnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              if (st == S_ADDR) begin
                rw <= sh[0];
                if (sh[7:1] == tgt_addr) begin
                  st <= S_AACK; sda_oe <= 1'b1;
                end else st <= S_IDLE;
              end else begin
                st <= S_RACK; sda_oe <= 1'b1;
                case (wcnt)
                  2'd0:    ptr[15:8] <= sh;
                  2'd1:    ptr[7:0]  <= sh;
                  default: begin mem_we <= 1'b1; mem_wdata <= sh; end
                endcase
                if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bcnt <= '0;
            if (rw) begin
              sh <= mem_rdata; sda_oe <= ~mem_rdata[7]; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
          S_RACK: if (scl_fall) begin
            sda_oe <= 1'b0; st <= S_RX;
          end
          S_TX: begin
            if (scl_rise) bcnt <= bcnt + 4'd1;
            else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_TACK; ptr <= ptr + 16'd1;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
              end
            end
          end
          S_TACK: begin
            if (scl_rise) nack <= sda;
            else if (scl_fall) begin
              bcnt <= '0;
              if (nack) st <= S_IDLE;
              else begin
                sh <= mem_rdata; sda_oe <= ~mem_rdata[7]; st <= S_TX;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl); // R10
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == S_IDLE) && !sda_oe); // R10
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr == $past(ptr) + 16'd1); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R6
  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TACK && scl_fall && nack && !start && !stop) |=> !sda_oe); // R7
endmodule

// File: tb/test_i2c_regmem_target.sv
module test_i2c_regmem_target;
  localparam int ADDR_W = 8;
  localparam int FILT   = 3;
  localparam int H      = 24;
  localparam logic [6:0] TA = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regmem_target #(.ADDR_W(ADDR_W), .FILT(FILT)) i_i2c_regmem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .tgt_addr(TA), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata));

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11);
  endfunction

  logic [7:0] ram [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_ptr;
  int nvec = 0, nfail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= init_val(i);
    end else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H/2);
  endtask

  task automatic i2c_rstart();
    sda_m = 1; w(H/2); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(H/2);
  endtask

  task automatic i2c_stop();
    sda_m = 0; w(H/2); scl_m = 1; w(H); sda_m = 1; w(2*H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(H/4);
      if (glitch) begin scl_m = 1; w(2); scl_m = 0; end
      w(H/4); scl_m = 1; w(H/2);
      if (glitch) begin sda_m = ~b[i]; w(2); sda_m = b[i]; end
      w(H/2); scl_m = 0; w(H/2);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    sda_m = 1; w(H/2); scl_m = 1; w(H/2); ack = !sda_bus; w(H/2); scl_m = 0; w(H/2);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(H/2); scl_m = 1; w(H/2); b[i] = sda_bus; w(H/2); scl_m = 0;
    end
    sda_m = !mack; w(H/2); scl_m = 1; w(H); scl_m = 0; w(2); sda_m = 1; w(H/2);
  endtask

  task automatic addr_phase(input logic [15:0] a, input bit glitch);
    bit ack;
    send({TA, 1'b0}, glitch, ack); chk("R6 address ack", ack, 1);
    send(a[15:8], glitch, ack);    chk("R1 pointer high ack", ack, 1);
    send(a[7:0], glitch, ack);     chk("R1 pointer low ack", ack, 1);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d[$], input bit glitch);
    bit ack;
    i2c_start();
    addr_phase(a, glitch);
    foreach (d[i]) begin
      send(d[i], glitch, ack); chk("R6 data ack", ack, 1);
      exp_mem[8'(a + 16'(i))] = d[i];
    end
    i2c_stop();
    exp_ptr = a + 16'(d.size());
  endtask

  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b);
      chk(req, b, exp_mem[8'(exp_ptr)]);
      exp_ptr = exp_ptr + 16'd1;
    end
  endtask

  task automatic do_read_comb(input logic [15:0] a, input int n);
    bit ack;
    i2c_start();
    addr_phase(a, 0);
    i2c_rstart();
    send({TA, 1'b1}, 0, ack); chk("R5 read address ack", ack, 1);
    exp_ptr = a;
    read_bytes(n, "R5 combined read data");
    w(4); chk("R7 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic do_read_cur(input int n);
    bit ack;
    i2c_start();
    send({TA, 1'b1}, 0, ack); chk("R4 read address ack", ack, 1);
    read_bytes(n, "R4 current-address data");
    i2c_stop();
  endtask

  task automatic check_mem(string req);
    int bad = -1;
    for (int i = 255; i >= 0; i--) if (ram[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(req, 0, 0);
    else chk({req, " memory byte"}, ram[bad], exp_mem[bad]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    bit ack;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    exp_ptr = 16'h0000;
    w(10); rst_n = 1; w(10);

    chk("R11 SDA released after reset", sda_oe, 0);
    chk("R11 no write after reset", mem_we, 0);
    do_read_cur(1);

    i2c_start(); addr_phase(16'h0123, 0); i2c_stop(); exp_ptr = 16'h0123;
    check_mem("R2 pointer-only write stores nothing");
    do_read_cur(2);

    q = {8'hA5, 8'h3C, 8'h00, 8'hFF};
    do_write(16'h0040, q, 0);
    check_mem("R3 burst write");
    do_read_comb(16'h0040, 4);
    do_read_cur(2);

    q = {8'h5A, 8'hC3};
    do_write(16'hFFFF, q, 0);
    check_mem("R8 write across wrap");
    chk("R8 wrapped pointer", exp_ptr, 16'h0001);
    do_read_comb(16'hFFFF, 3);

    i2c_start();
    send({TA ^ 7'h01, 1'b0}, 0, ack); chk("R6 mismatch not acked", ack, 0);
    send(8'h00, 0, ack); chk("R6 ignored byte not acked", ack, 0);
    send(8'h77, 0, ack); chk("R6 ignored byte not acked", ack, 0);
    i2c_stop();
    check_mem("R6 mismatch stores nothing");
    do_read_cur(1);

    i2c_start(); addr_phase(16'h0010, 0);
    send_bits(8'hEE, 4, 0);
    i2c_rstart();
    send({TA, 1'b1}, 0, ack); chk("R10 read after aborted byte acked", ack, 1);
    exp_ptr = 16'h0010;
    read_bytes(1, "R10 aborted byte not stored");
    i2c_stop();
    check_mem("R10 abort stores nothing");

    sda_m = 0; w(2); sda_m = 1; w(H);
    q = {8'h96, 8'h69};
    do_write(16'h0080, q, 1);
    check_mem("R9 glitches filtered");
    do_read_comb(16'h0080, 2);

    for (int t = 0; t < 8; t++) begin
      logic [15:0] a = 16'($urandom);
      int n = 1 + int'($urandom % 4);
      q = {};
      for (int k = 0; k < n; k++) q.push_back(8'($urandom));
      do_write(a, q, 0);
      check_mem("R3 random burst write");
      do_read_comb(a, n);
      do_read_cur(1 + int'($urandom % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule